// File: doc/BRIEF.md
# Grayscale Chain Serial Shifter

This block keeps a 12-bit brightness level for every output of a chain of LED PWM driver chips (16 outputs per chip) and, when a sequencer asks for it, pushes the whole set out as one continuous frame over a two-wire, write-only serial link (a serial clock and a data line). The frame goes out in reverse channel order: the highest-numbered output of the chip furthest down the chain is sent first, and output 0 of the first chip is sent last. Each level goes out most significant bit first. After the last clock pulse the block pulses `done`, so the sequencer can latch the data into the chips.

Software or a controlling state machine sets levels through a valid/ready write port, one channel per transfer. The port never applies back-pressure: `wr_ready` stays high, and each cycle with `wr_valid` high stores one level. The levels are copied into the shifter in the cycle a frame starts. A write made during a frame, including one in the same cycle as the start, therefore changes only the next frame. The serial clock comes from an integer divider of the system clock and has equal high and low phases. For the default of four chips the frame is 768 serial clocks long.

Top module: `grayscale_chain_shifter`

## Requirements
- R1: After reset every channel level is 0, `sclk`, `mosi`, `busy` and `done` are low, and a frame started before any write shifts out all zeros.
- R2: One frame has exactly 192 × NUM_CHIPS rising edges of `sclk`, which is 768 for the default of four chips.
- R3: Channel index c = chip × 16 + output, with c in 0 to 16 × NUM_CHIPS − 1. Levels go out in descending channel index, from the highest index down to channel 0, with no gap between channels.
- R4: Within a level, bit 11 is sent first and bit 0 last. Bit k of the frame (counting from 0) is bit 11 − (k mod 12) of channel (16 × NUM_CHIPS − 1) − k/12.
- R5: Link timing follows SPI mode 0. `sclk` is low whenever `busy` is low. `mosi` changes only while `sclk` is low, so it holds steady across every rising edge.
- R6: Each `sclk` period lasts 2 × SCLK_HALF system clocks, split into SCLK_HALF cycles high and SCLK_HALF cycles low, with no pause between bits.
- R7: `done` is high for exactly one cycle, in the same cycle that `busy` falls. That cycle comes 2 × SCLK_HALF × FRAME_BITS clocks after the clock edge that accepted `start`, which is also the edge of the final falling edge of `sclk`.
- R8: A `start` while `busy` is high is ignored: the frame in progress keeps its length, its data and its `done` timing.
- R9: The levels are captured in the cycle `start` is accepted. A write in that same cycle, or during the frame, appears only in the next frame.
- R10: `wr_ready` is always high. A cycle with `wr_valid` high stores `wr_level` into the channel selected by `wr_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| wr_valid | input | 1 | Level write request |
| wr_ready | output | 1 | Write accepted (always high) |
| wr_addr | input | $clog2(16*NUM_CHIPS) | Channel index chip*16+output |
| wr_level | input | 12 | Level, 0 off to 0xFFF full on |
| start | input | 1 | Begin a frame (ignored while busy) |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data, valid at the rising edge of sclk |

## Verification
The hardest case to reach from the ports is a level write that lands in the same clock edge as the accepted start, together with writes and a second start pulse while the frame is running. The stimulus drives such a write on the exact cycle it raises `start`. A second branch writes random channels and pulses `start` partway through the frame. The expected frame comes from a copy of the levels taken before the coincident write, and the frame after it must show every update.

// File: rtl/gsc_pkg.sv
package gsc_pkg;
  localparam int GSC_OUTS_PER_CHIP = 16;
  localparam int GSC_LEVEL_W       = 12;

  typedef enum logic [0:0] {
    SH_IDLE = 1'b0,
    SH_RUN  = 1'b1
  } sh_state_t;

  function automatic int gsc_frame_bits(input int chips);
    return chips * GSC_OUTS_PER_CHIP * GSC_LEVEL_W;
  endfunction
endpackage

// File: rtl/gsc_level_bank.sv
module gsc_level_bank #(
  parameter int NUM_CH  = 64,
  parameter int LEVEL_W = 12,
  parameter int ADDR_W  = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [LEVEL_W-1:0]         wr_level,
  output logic [NUM_CH*LEVEL_W-1:0]  levels_flat
);
  // One register per channel; channel c sits at bits [c*LEVEL_W +: LEVEL_W],
  // so the highest channel ends up in the most significant slice.
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [LEVEL_W-1:0] level_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        level_q <= '0;
      else if (wr_en && (wr_addr == ADDR_W'(ch)))
        level_q <= wr_level;
    end
    assign levels_flat[ch*LEVEL_W +: LEVEL_W] = level_q;
  end
endmodule

// File: rtl/gsc_phase_timer.sv
module gsc_phase_timer #(
  parameter int SCLK_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(SCLK_HALF - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run)
      cnt_q <= '0;
    else if (tick)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/gsc_frame_shifter.sv
module gsc_frame_shifter
  import gsc_pkg::*;
#(
  parameter int FRAME_BITS = 768
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] snap,
  input  logic                  tick,
  output logic                  busy,
  output logic                  done,
  output logic                  sclk,
  output logic                  mosi
);
  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);

  sh_state_t             state_q;
  logic [FRAME_BITS-1:0] shreg_q;
  logic [BW-1:0]         bit_q;
  logic                  sclk_q;
  logic                  done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SH_IDLE;
      shreg_q <= '0;
      bit_q   <= '0;
      sclk_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        SH_IDLE: begin
          if (start) begin
            shreg_q <= snap;
            bit_q   <= '0;
            sclk_q  <= 1'b0;
            state_q <= SH_RUN;
          end
        end
        SH_RUN: begin
          if (tick) begin
            if (!sclk_q) begin
              sclk_q <= 1'b1;
            end else begin
              sclk_q  <= 1'b0;
              shreg_q <= {shreg_q[FRAME_BITS-2:0], 1'b0};
              if (bit_q == LAST_BIT) begin
                state_q <= SH_IDLE;
                done_q  <= 1'b1;
              end else begin
                bit_q <= bit_q + 1'b1;
              end
            end
          end
        end
        default: state_q <= SH_IDLE;
      endcase
    end
  end

  assign busy = (state_q == SH_RUN);
  assign done = done_q;
  assign sclk = sclk_q;
  assign mosi = shreg_q[FRAME_BITS-1];
endmodule

// File: rtl/grayscale_chain_shifter.sv
module grayscale_chain_shifter
  import gsc_pkg::*;
#(
  parameter int NUM_CHIPS = 4,
  parameter int SCLK_HALF = 4,
  parameter int OUTS      = GSC_OUTS_PER_CHIP,
  parameter int LEVEL_W   = GSC_LEVEL_W,
  parameter int NUM_CH    = NUM_CHIPS * OUTS,
  parameter int ADDR_W    = $clog2(NUM_CH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [LEVEL_W-1:0] wr_level,
  input  logic               start,
  output logic               busy,
  output logic               done,
  output logic               sclk,
  output logic               mosi
);
  localparam int FRAME_BITS = NUM_CH * LEVEL_W;

  logic [FRAME_BITS-1:0] levels_flat;
  logic                  tick;

  assign wr_ready = 1'b1;

  gsc_level_bank #(
    .NUM_CH (NUM_CH),
    .LEVEL_W(LEVEL_W),
    .ADDR_W (ADDR_W)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_valid && wr_ready),
    .wr_addr    (wr_addr),
    .wr_level   (wr_level),
    .levels_flat(levels_flat)
  );

  gsc_phase_timer #(
    .SCLK_HALF(SCLK_HALF)
  ) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .tick (tick)
  );

  gsc_frame_shifter #(
    .FRAME_BITS(FRAME_BITS)
  ) u_shift (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .snap (levels_flat),
    .tick (tick),
    .busy (busy),
    .done (done),
    .sclk (sclk),
    .mosi (mosi)
  );
endmodule

// File: rtl/gsc_checker.sv
module gsc_checker #(
  parameter int FRAME_BITS = 768
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic sclk,
  input logic mosi
);
  localparam int RW = $clog2(FRAME_BITS + 1);

  logic          sclk_d;
  logic [RW-1:0] rises_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      rises_q <= '0;
    end else begin
      sclk_d <= sclk;
      if (done)
        rises_q <= '0;
      else if (sclk && !sclk_d)
        rises_q <= rises_q + 1'b1;
    end
  end

  assert_sclk_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  assert_mosi_hold_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_with_busy_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_frame_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rises_q == RW'(FRAME_BITS)));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(sclk && !done)) |=> busy);

  assert_busy_from_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind grayscale_chain_shifter gsc_checker #(
  .FRAME_BITS(NUM_CH * LEVEL_W)
) u_gsc_checker (
  .clk  (clk),
  .rst_n(rst_n),
  .start(start),
  .busy (busy),
  .done (done),
  .sclk (sclk),
  .mosi (mosi)
);

// File: tb/tb_grayscale_chain_shifter.sv
module tb_grayscale_chain_shifter;
  localparam int CHIPS = 4;
  localparam int HALF  = 4;
  localparam int NCH   = CHIPS * 16;
  localparam int FB    = NCH * 12;
  localparam int AW    = $clog2(NCH);
  localparam int FRAME_CYC = 2 * HALF * FB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [11:0] wr_level = '0;
  logic start = 1'b0;
  logic busy, done, sclk, mosi;

  always #2.5 clk = ~clk;

  grayscale_chain_shifter #(.NUM_CHIPS(CHIPS), .SCLK_HALF(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_level(wr_level), .start(start), .busy(busy),
    .done(done), .sclk(sclk), .mosi(mosi)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [11:0] model [NCH];
  logic [11:0] expv  [NCH];
  logic        cap   [FB];

  // negedge monitor of the serial link
  int  rises = 0, gap_err = 0, hi_err = 0, hold_err = 0, dones = 0;
  int  gap = 0, hi_len = 0;
  logic p_sclk = 1'b0, p_mosi = 1'b0, p_busy = 1'b0;

  always @(negedge clk) begin
    if (busy && !p_busy) begin
      rises = 0; gap_err = 0; hi_err = 0; hold_err = 0; dones = 0; gap = 0;
    end
    gap++;
    if (sclk && !p_sclk) begin
      if (rises > 0 && gap != 2 * HALF) gap_err++;
      if (rises < FB) cap[rises] = mosi;
      rises++;
      gap = 0;
      hi_len = 1;
    end else if (sclk) begin
      hi_len++;
      if (mosi != p_mosi) hold_err++;
    end
    if (!sclk && p_sclk && hi_len != HALF) hi_err++;
    if (done) dones++;
    p_sclk = sclk; p_mosi = mosi; p_busy = busy;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_lvl(input int a, input logic [11:0] v);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = AW'(a); wr_level = v;
    check(wr_ready === 1'b1, "R10 wr_ready", wr_ready, 1);
    @(negedge clk);
    wr_valid = 1'b0;
    model[a] = v;
  endtask

  function automatic logic exp_bit(input int k);
    int ch = NCH - 1 - k / 12;
    int b  = 11 - (k % 12);
    return expv[ch][b];
  endfunction

  task automatic run_frame(input bit co_wr, input int co_a, input logic [11:0] co_v,
                           input bit noisy, input string tag);
    int cnt;
    int mism;
    for (int i = 0; i < NCH; i++) expv[i] = model[i];
    @(negedge clk);
    start = 1'b1;
    if (co_wr) begin wr_valid = 1'b1; wr_addr = AW'(co_a); wr_level = co_v; end
    @(negedge clk);
    start = 1'b0; wr_valid = 1'b0;
    if (co_wr) model[co_a] = co_v;
    cnt = 1;
    fork
      begin
        while (!done && cnt < FRAME_CYC + 50) begin
          @(negedge clk);
          cnt++;
          if (noisy && cnt == 300) start = 1'b1;
          if (noisy && cnt == 301) start = 1'b0;
        end
      end
      begin
        if (noisy) begin
          for (int j = 0; j < 6; j++) begin
            int a = int'($urandom % NCH);
            logic [11:0] v = 12'($urandom);
            repeat (200) @(negedge clk);
            wr_valid = 1'b1; wr_addr = AW'(a); wr_level = v;
            @(negedge clk);
            wr_valid = 1'b0;
            model[a] = v;
          end
        end
      end
    join
    check(cnt == FRAME_CYC + 1, {"R7 done cycle ", tag}, cnt, FRAME_CYC + 1);
    check(busy === 1'b0, {"R7 busy low with done ", tag}, busy, 0);
    check(rises == FB, {"R2 rising edges ", tag}, rises, FB);
    check(gap_err == 0, {"R6 sclk period ", tag}, gap_err, 0);
    check(hi_err == 0, {"R6 sclk high phase ", tag}, hi_err, 0);
    check(hold_err == 0, {"R5 mosi held while sclk high ", tag}, hold_err, 0);
    mism = 0;
    for (int k = 0; k < FB; k++) if (cap[k] !== exp_bit(k)) begin
      if (mism == 0) $display("FAIL R3/R4 %s first bad bit %0d actual=%0b expected=%0b",
                              tag, k, cap[k], exp_bit(k));
      mism++;
    end
    total++;
    if (mism != 0) bad++;
    repeat (3) @(negedge clk);
    check(dones == 1, {"R7 single done pulse ", tag}, dones, 1);
    check(sclk === 1'b0 && busy === 1'b0, {"R5 idle sclk low ", tag}, sclk, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NCH; i++) model[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sclk === 1'b0, "R1 sclk reset", sclk, 0);
    check(mosi === 1'b0, "R1 mosi reset", mosi, 0);
    check(busy === 1'b0, "R1 busy reset", busy, 0);
    check(done === 1'b0, "R1 done reset", done, 0);
    run_frame(1'b0, 0, 12'h0, 1'b0, "R1 zero frame");

    // directed corners: extreme channels and chip boundaries (R3, R4)
    write_lvl(0, 12'hFFF);
    write_lvl(NCH - 1, 12'h800);
    write_lvl(15, 12'h001);
    write_lvl(16, 12'hA5C);
    write_lvl(NCH - 16, 12'h3C7);
    run_frame(1'b0, 0, 12'h0, 1'b0, "R3 R4 directed");

    // random full set
    for (int i = 0; i < NCH; i++) write_lvl(i, 12'($urandom));
    run_frame(1'b0, 0, 12'h0, 1'b0, "R3 R4 random");

    // R9 coincident write plus R8 mid-frame start and writes
    run_frame(1'b1, NCH - 1, 12'h5A5, 1'b1, "R8 R9 snapshot");
    run_frame(1'b0, 0, 12'h0, 1'b0, "R9 next frame");

    // alternating pattern
    for (int i = 0; i < NCH; i++) write_lvl(i, (i % 2) ? 12'hAAA : 12'h555);
    run_frame(1'b0, 0, 12'h0, 1'b0, "R4 alternating");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule